// File: doc/BRIEF.md
# Two-Rail Return-to-Zero Serial Word Transmitter

This block sends 32-bit avionics data words one bit at a time on two logic rails in return-to-zero form. A host on a synchronous 16-bit bus writes each word in two halves. A lower-half strobe captures bits [15:0] into a holding register. An upper-half strobe supplies bits [31:16] and pushes the whole word into a small queue. A third strobe loads the control register. In that register, bit 4 asks for parity insertion and bit 7 selects the slow bit rate. The other bus bits have no effect on the control register.

Words are sent only while the transmit enable input is high, and the host loads the queue while enable is low. When enable falls, the queue is emptied and any word in progress is dropped. A continuous bit clock output runs in phase with the data. Successive words are separated by a fixed quiet gap. A parity-force pin can require parity insertion even when the control bit asks for none. All inputs are synchronous to the master clock.

The state machine has three states:
- IDLE: waiting, with both rails low.
- SEND: shifting out the 32 bits.
- GAP: counting the quiet bit times.

Its transitions are:
- start: IDLE to SEND, or GAP to SEND at the end of the last gap bit. It happens on a bit boundary while enable is high and the queue holds a word. It pops the word.
- word done: SEND to GAP, after bit 32.
- abort: SEND to GAP, when enable falls.
- gap over: GAP to IDLE, at the end of the last gap bit when no start is possible.

Top module: `a429_tx`

## Requirements
- R1: A falling edge on `ld_lo_n` captures `bus_in` as word bits [15:0]. A falling edge on `ld_hi_n` takes `bus_in` as bits [31:16] and pushes the assembled word into the queue.
- R2: Half-word strobes have no effect while `xmit_en` is high.
- R3: Queued words are held while `xmit_en` is low. They are transmitted, oldest first, once it is high.
- R4: A falling edge on `xmit_en` empties the queue and abandons the word in progress. Both rails are low from the next cycle on, and `tx_ready` is high.
- R5: `tx_ready` is high exactly when the queue is empty. The queue holds FIFO_DEPTH words, and a push into a full queue is dropped.
- R6: Word bit 0 is sent first and bit 31 last. For a 1, `rz_one` is high during the first half of the bit time; for a 0, `rz_zero` is high. Both rails are low during the second half, and both are never high together.
- R7: `bit_clk` runs at all times at the bit rate. It is high during the first half of each bit time, and every bit starts on its rising edge.
- R8: A bit lasts HI_DIV clocks (10) when control bit 7 is 0 and LO_DIV clocks (80) when it is 1.
- R9: If control bit 4 is 1 or `par_force` is high, word bit 31 is replaced by odd parity over bits 30..0, so the sent word has an odd number of ones. Otherwise bit 31 is sent unchanged.
- R10: When the next word is already queued and enabled, GAP_BITS full bit times with both rails low follow the second half of bit 32 before the next word starts.
- R11: A falling edge on `ld_ctrl_n` loads bits 4 and 7 of `bus_in` into the control register. `rst_n` leaves the control register unchanged.
- R12: While `rst_n` is low, the queue, the counters and the state machine are cleared, `tx_ready` is high and both rails are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (1 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low master reset |
| bus_in | input | 16 | Host write data |
| ld_ctrl_n | input | 1 | Active-low control register load strobe |
| ld_lo_n | input | 1 | Active-low lower half-word strobe |
| ld_hi_n | input | 1 | Active-low upper half-word strobe and push |
| xmit_en | input | 1 | Transmit enable; falling edge clears the queue |
| par_force | input | 1 | High forces parity insertion |
| rz_one | output | 1 | Rail high in the first half of a 1 bit |
| rz_zero | output | 1 | Rail high in the first half of a 0 bit |
| bit_clk | output | 1 | Continuous bit-rate clock, high in the first half |
| tx_ready | output | 1 | High when the queue is empty |

## Verification
The bench builds the block with FIFO_DEPTH set to 4. At that depth a fifth write overflows the queue, so the drop rule is tested in a few strobes. HI_DIV 10, LO_DIV 80 and GAP_BITS 4 keep their defaults. With these values the bench checks exact per-clock timing at both rates and measures the gap as exactly 40 clocks at the fast rate.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int WORD_W        = 32;
    localparam int HALF_W        = 16;
    localparam int CTRL_PAR_BIT  = 4;
    localparam int CTRL_RATE_BIT = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_t;

    // Replace the top bit with odd parity over the lower bits when asked.
    function automatic logic [WORD_W-1:0] with_parity(input logic [WORD_W-1:0] w,
                                                      input logic             ins);
        return ins ? {~^w[WORD_W-2:0], w[WORD_W-2:0]} : w;
    endfunction

endpackage

// File: rtl/a429_tx_host.sv
module a429_tx_host
    import a429_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] bus_in,
    input  logic              ld_ctrl_n,
    input  logic              ld_lo_n,
    input  logic              ld_hi_n,
    input  logic              xmit_en,
    output logic              par_en,
    output logic              lo_rate,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              en_fall
);

    logic              ctrl_prev_q, lo_prev_q, hi_prev_q, en_q;
    logic [HALF_W-1:0] lo_half_q;
    logic              ctrl_fall, lo_fall, hi_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_prev_q <= 1'b1;
            lo_prev_q   <= 1'b1;
            hi_prev_q   <= 1'b1;
            en_q        <= 1'b0;
        end else begin
            ctrl_prev_q <= ld_ctrl_n;
            lo_prev_q   <= ld_lo_n;
            hi_prev_q   <= ld_hi_n;
            en_q        <= xmit_en;
        end
    end

    assign ctrl_fall = ctrl_prev_q & ~ld_ctrl_n;
    assign lo_fall   = lo_prev_q & ~ld_lo_n;
    assign hi_fall   = hi_prev_q & ~ld_hi_n;
    assign en_fall   = en_q & ~xmit_en;

    // Control bits survive master reset, so this register has none.
    always_ff @(posedge clk) begin
        if (ctrl_fall) begin
            par_en  <= bus_in[CTRL_PAR_BIT];
            lo_rate <= bus_in[CTRL_RATE_BIT];
        end
        if (lo_fall && !xmit_en) begin
            lo_half_q <= bus_in;
        end
    end

    assign push      = hi_fall & ~xmit_en;
    assign push_word = {bus_in, lo_half_q};

endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push & ~full & ~clr;
    assign do_pop  = pop & ~empty & ~clr;
    assign dout    = mem[rd_q];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

endmodule

// File: rtl/a429_tx_baud.sv
module a429_tx_baud #(
    parameter int HI_DIV = 10,
    parameter int LO_DIV = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_rate,
    output logic bit_end,
    output logic first_half
);

    localparam int MAXDIV = (LO_DIV > HI_DIV) ? LO_DIV : HI_DIV;
    localparam int PW     = $clog2(MAXDIV);

    logic [PW-1:0] ph_q;
    logic [PW-1:0] last_ph, half_ph;

    assign last_ph    = lo_rate ? PW'(LO_DIV - 1) : PW'(HI_DIV - 1);
    assign half_ph    = lo_rate ? PW'(LO_DIV / 2) : PW'(HI_DIV / 2);
    assign bit_end    = (ph_q >= last_ph);
    assign first_half = (ph_q < half_ph);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ph_q <= '0;
        else if (bit_end) ph_q <= '0;
        else              ph_q <= ph_q + 1'b1;
    end

endmodule

// File: rtl/a429_tx.sv
module a429_tx
    import a429_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int HI_DIV     = 10,
    parameter int LO_DIV     = 80,
    parameter int GAP_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] bus_in,
    input  logic              ld_ctrl_n,
    input  logic              ld_lo_n,
    input  logic              ld_hi_n,
    input  logic              xmit_en,
    input  logic              par_force,
    output logic              rz_one,
    output logic              rz_zero,
    output logic              bit_clk,
    output logic              tx_ready
);

    localparam int BW = $clog2(WORD_W);
    localparam int GW = $clog2(GAP_BITS + 1);

    logic              par_en, lo_rate, push, en_fall;
    logic [WORD_W-1:0] push_word, fifo_dout;
    logic              fifo_empty, fifo_full, pop;
    logic              bit_end, first_half;

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q, shreg_d;
    logic [BW-1:0]     bcnt_q, bcnt_d;
    logic [GW-1:0]     gcnt_q, gcnt_d;
    logic              gap_last, can_start;

    a429_tx_host i_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus_in),
        .ld_ctrl_n (ld_ctrl_n),
        .ld_lo_n   (ld_lo_n),
        .ld_hi_n   (ld_hi_n),
        .xmit_en   (xmit_en),
        .par_en    (par_en),
        .lo_rate   (lo_rate),
        .push      (push),
        .push_word (push_word),
        .en_fall   (en_fall)
    );

    a429_tx_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (en_fall),
        .push  (push),
        .din   (push_word),
        .pop   (pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    a429_tx_baud #(.HI_DIV(HI_DIV), .LO_DIV(LO_DIV)) i_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_rate    (lo_rate),
        .bit_end    (bit_end),
        .first_half (first_half)
    );

    assign gap_last  = (gcnt_q == GW'(GAP_BITS - 1));
    assign can_start = bit_end & xmit_en & ~fifo_empty;
    assign pop       = can_start & ((state_q == ST_IDLE) ||
                                    ((state_q == ST_GAP) && gap_last));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        bcnt_d  = bcnt_q;
        gcnt_d  = gcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pop) begin
                    state_d = ST_SEND;
                    shreg_d = with_parity(fifo_dout, par_en | par_force);
                    bcnt_d  = '0;
                end
            end
            ST_SEND: begin
                if (en_fall) begin
                    state_d = ST_GAP;
                    gcnt_d  = '0;
                end else if (bit_end) begin
                    if (bcnt_q == BW'(WORD_W - 1)) begin
                        state_d = ST_GAP;
                        gcnt_d  = '0;
                    end else begin
                        shreg_d = shreg_q >> 1;
                        bcnt_d  = bcnt_q + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (bit_end) begin
                    if (!gap_last) begin
                        gcnt_d = gcnt_q + 1'b1;
                    end else if (pop) begin
                        state_d = ST_SEND;
                        shreg_d = with_parity(fifo_dout, par_en | par_force);
                        bcnt_d  = '0;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            bcnt_q  <= '0;
            gcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            bcnt_q  <= bcnt_d;
            gcnt_q  <= gcnt_d;
        end
    end

    // Outputs
    always_comb begin
        rz_one   = 1'b0;
        rz_zero  = 1'b0;
        bit_clk  = first_half;
        tx_ready = fifo_empty;
        if (state_q == ST_SEND && first_half) begin
            rz_one  = shreg_q[0];
            rz_zero = ~shreg_q[0];
        end
    end

endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic xmit_en,
    input logic tx_ready,
    input logic rz_one,
    input logic rz_zero,
    input logic bit_clk
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r6_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rz_one && rz_zero));

    a_r6_second_half_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_clk |-> (!rz_one && !rz_zero));

    a_r4_clear_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(xmit_en)) |=> tx_ready);

    a_r3_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !xmit_en && $past(!xmit_en)) |-> (!rz_one && !rz_zero));

    a_r2_no_write_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit_en && tx_ready) |=> tx_ready);

    a_r12_reset_ready: assert property (@(posedge clk)
        !rst_n |-> (tx_ready && !rz_one && !rz_zero));

endmodule

bind a429_tx a429_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xmit_en  (xmit_en),
    .tx_ready (tx_ready),
    .rz_one   (rz_one),
    .rz_zero  (rz_zero),
    .bit_clk  (bit_clk)
);

// File: tb/test_a429_tx.sv
module test_a429_tx;

    localparam int DEPTH = 4;
    localparam int HI    = 10;
    localparam int LO    = 80;
    localparam int GAP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_in = '0;
    logic        ld_ctrl_n = 1'b1, ld_lo_n = 1'b1, ld_hi_n = 1'b1;
    logic        xmit_en = 1'b0, par_force = 1'b0;
    logic        rz_one, rz_zero, bit_clk, tx_ready;

    always #10 clk = ~clk;

    a429_tx #(.FIFO_DEPTH(DEPTH), .HI_DIV(HI), .LO_DIV(LO), .GAP_BITS(GAP)) i_a429_tx (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_ctrl_n(ld_ctrl_n),
        .ld_lo_n(ld_lo_n), .ld_hi_n(ld_hi_n), .xmit_en(xmit_en),
        .par_force(par_force), .rz_one(rz_one), .rz_zero(rz_zero),
        .bit_clk(bit_clk), .tx_ready(tx_ready)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Columns: word, expected sent word, parity bit, force pin, slow rate
    localparam logic [66:0] VEC [8] = '{
        {32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0, 1'b0},
        {32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b0},
        {32'h0000_0003, 32'h0000_0003, 1'b0, 1'b0, 1'b0},
        {32'h0000_0003, 32'h8000_0003, 1'b0, 1'b1, 1'b0},
        {32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0, 1'b1},
        {32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0, 1'b0},
        {32'h0F0F_00FF, 32'h8F0F_00FF, 1'b0, 1'b1, 1'b1},
        {32'h8000_0001, 32'h0000_0001, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ld_ctrl_n = 1'b0;
            1: ld_lo_n   = 1'b0;
            default: ld_hi_n = 1'b0;
        endcase
        repeat (2) @(negedge clk);
        ld_ctrl_n = 1'b1; ld_lo_n = 1'b1; ld_hi_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_ctrl(input bit par, input bit slow);
        bus_in = (16'(par) << 4) | (16'(slow) << 7);
        pulse(0);
    endtask

    task automatic load_word(input logic [31:0] w);
        bus_in = w[15:0];
        pulse(1);
        bus_in = w[31:16];
        pulse(2);
    endtask

    task automatic capture(input int div, output logic [31:0] w, output bit found,
                           output bit enc_ok, output bit clk_ok);
        found = 0; enc_ok = 1; clk_ok = 1; w = '0;
        for (int i = 0; i < 2000 && !found; i++) begin
            @(negedge clk);
            if (rz_one || rz_zero) found = 1;
        end
        if (found) begin
            for (int b = 0; b < 32; b++) begin
                w[b] = rz_one;
                if (rz_one == rz_zero) enc_ok = 0;
                if (!bit_clk) clk_ok = 0;
                repeat (div / 2) @(negedge clk);
                if (rz_one || rz_zero) enc_ok = 0;
                if (bit_clk) clk_ok = 0;
                repeat (div / 2) @(negedge clk);
            end
        end
    endtask

    task automatic watch(input int cycles, output bit seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rz_one || rz_zero) seen = 1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        bit          found, enc_ok, clk_ok, seen;
        int          gap_n, rises;
        logic        prev_clk;

        repeat (3) @(negedge clk);
        // R12: reset state
        check(tx_ready && !rz_one && !rz_zero, "R12", "reset state",
              {29'd0, tx_ready, rz_one, rz_zero}, 32'h4);
        rst_n = 1'b1;
        load_ctrl(1'b0, 1'b0);

        // R7: continuous bit clock, 10 rises in 100 clocks
        rises = 0;
        @(negedge clk); prev_clk = bit_clk;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (bit_clk && !prev_clk) rises++;
            prev_clk = bit_clk;
        end
        check(rises == 10, "R7", "bit clock rises per 100 clocks", rises, 10);

        // Vector table: R1 R5 R6 R7 R8 R9 R11
        for (int v = 0; v < 8; v++) begin
            logic [31:0] w_in, w_exp;
            logic        vpar, vfrc, vslow;
            {w_in, w_exp, vpar, vfrc, vslow} = VEC[v];
            load_ctrl(vpar, vslow);
            par_force = vfrc;
            load_word(w_in);
            check(!tx_ready, "R5", "ready low after load", tx_ready, 0);
            xmit_en = 1'b1;
            capture(vslow ? LO : HI, got, found, enc_ok, clk_ok);
            check(found && got == w_exp, "R9", "sent word (R1 R8 R11)", got, w_exp);
            check(enc_ok, "R6", "rail encoding", enc_ok, 1);
            check(clk_ok, "R7", "bit clock phase (R8)", clk_ok, 1);
            xmit_en = 1'b0;
            par_force = 1'b0;
            repeat (3) @(negedge clk);
        end
        load_ctrl(1'b0, 1'b0);

        // R3 hold while disabled, R10 gap between back-to-back words
        load_word(32'hA5A5_0F0F);
        load_word(32'h0000_8001);
        watch(300, seen);
        check(!seen && !tx_ready, "R3", "held while disabled", seen, 0);
        xmit_en = 1'b1;
        capture(HI, got, found, enc_ok, clk_ok);
        check(got == 32'hA5A5_0F0F, "R3", "first queued word", got, 32'hA5A5_0F0F);
        gap_n = 0;
        while (!(rz_one || rz_zero) && gap_n < 5000) begin
            gap_n++;
            @(negedge clk);
        end
        check(gap_n == GAP * HI, "R10", "gap clocks", gap_n, GAP * HI);
        capture(HI, got, found, enc_ok, clk_ok);
        check(got == 32'h0000_8001, "R3", "second queued word", got, 32'h0000_8001);

        // R2: writes ignored while enabled
        repeat (5) @(negedge clk);
        load_word(32'h1111_2222);
        check(tx_ready, "R2", "ready stays high", tx_ready, 1);
        watch(400, seen);
        check(!seen, "R2", "no word sent", seen, 0);
        xmit_en = 1'b0;
        repeat (3) @(negedge clk);

        // R5: depth limit, fifth push dropped
        for (int k = 0; k < 5; k++) load_word(32'h0000_0100 + 32'(k));
        check(!tx_ready, "R5", "ready low when full", tx_ready, 0);
        xmit_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            capture(HI, got, found, enc_ok, clk_ok);
            check(got == 32'h0000_0100 + 32'(k), "R5", "queued order", got,
                  32'h0000_0100 + 32'(k));
        end
        watch(500, seen);
        check(!seen && tx_ready, "R5", "overflow word dropped", seen, 0);
        xmit_en = 1'b0;
        repeat (3) @(negedge clk);

        // R4: enable fall clears queue and aborts
        load_word(32'hFFFF_0000);
        load_word(32'h0000_FFFF);
        xmit_en = 1'b1;
        for (int i = 0; i < 2000 && !(rz_one || rz_zero); i++) @(negedge clk);
        repeat (3 * HI) @(negedge clk);
        xmit_en = 1'b0;
        repeat (2) @(negedge clk);
        check(!rz_one && !rz_zero && tx_ready, "R4", "abort and clear",
              {29'd0, tx_ready, rz_one, rz_zero}, 32'h4);
        xmit_en = 1'b1;
        watch(600, seen);
        check(!seen, "R4", "nothing left to send", seen, 0);
        xmit_en = 1'b0;
        repeat (3) @(negedge clk);

        // R11 R12: reset clears queue, keeps control
        load_ctrl(1'b1, 1'b0);
        load_word(32'h0000_0000);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_ready && !rz_one && !rz_zero, "R12", "reset clears queue",
              {29'd0, tx_ready, rz_one, rz_zero}, 32'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        load_word(32'h0000_0000);
        xmit_en = 1'b1;
        capture(HI, got, found, enc_ok, clk_ok);
        check(got == 32'h8000_0000, "R11", "control kept over reset", got, 32'h8000_0000);
        xmit_en = 1'b0;
        repeat (5) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule